// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable synchronous static RAM that takes one command on every enabled clock edge. Reads and writes can follow each other in any order with no idle cycles between them. Write data arrives late. In pipelined mode it comes two edges after its address. In flow-through mode it comes one edge after. This late arrival is what lets a read be followed at once by a write: the bus is never wanted by both sides in the same cycle.

A static mode input picks pipelined operation (an output register, so read data is driven after the edge that follows the address edge) or flow-through operation (no output register). Bursts of four are continued with the advance input. A companion counter steps the two low address bits. Writes still waiting for their data are kept in two stage registers. A pipelined read of an address whose write data is arriving on that same edge gets the merged new bytes.

The command decoder is a three-state machine: ST_DESEL (no access), ST_RD (read burst) and ST_WR (write burst). On a load cycle (advance low) it goes to ST_DESEL when the chip enables do not select the part. It goes to ST_RD when write-enable is high and to ST_WR when write-enable is low. On a continue cycle (advance high) it stays in its present state. A continue from ST_DESEL is therefore a deselect continue.

Top module: `zbt_sram_core`

## Requirements
- R1: During and right after reset, dq_oe is 0.
- R2: With flow_thru=0, a read whose address is sampled at edge k is driven on dq_out with dq_oe=1 in the cycle after edge k+1, and not in the cycle after edge k.
- R3: With flow_thru=1, a read sampled at edge k is driven on dq_out with dq_oe=1 in the cycle after edge k.
- R4: Write data on dq_in is sampled at edge k+2 (flow_thru=0) or k+1 (flow_thru=1) for a write command sampled at edge k, and dq_oe is 0 in the cycle before that sampling edge.
- R5: A load cycle is a deselect unless ce1_n=0, ce2=1 and ce3_n=0. A deselect writes nothing and does not drive the bus.
- R6: With adv=1 a cycle continues the current operation at the next burst address: the two low address bits increment by one and wrap from 3 to 0, and the upper bits are kept. With adv=0 the cycle loads a new address from addr.
- R7: A write with every bw_n bit high is a write abort: no byte changes, and the bus stays undriven.
- R8: bw_n[b]=0 enables byte b, which is dq bits [9b+8:9b]. Only the enabled bytes of the word change.
- R9: While cke_n=1 the clock edge is ignored. Commands, write data and state all hold, so a pipelined read that is being driven stays driven with the same data.
- R10: oe_n=1 forces dq_oe to 0 at once, within a cycle, whatever the internal state.
- R11: While sleep=1, dq_oe is 0 at once and all other inputs are ignored on clock edges.
- R12: A pipelined read issued on the edge right after a write to the same address returns the write's enabled bytes from dq_in, merged with the stored bytes.
- R13: Read, write, read issued on consecutive edges needs no idle cycle, and the bus is never driven in a cycle whose data is sampled as write data. A continue cycle after a deselect stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_thru | input | 1 | Static mode: 1 flow-through, 0 pipelined |
| cke_n | input | 1 | Clock enable, active low; high stalls the edge |
| addr | input | 10 | Word address for load cycles |
| adv | input | 1 | 1 continue burst, 0 load new address |
| we_n | input | 1 | Write enable on load cycles, active low |
| bw_n | input | 2 | Per-byte write enables, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq_in | input | 18 | Data bus input side (late write data) |
| dq_out | output | 18 | Data bus output side (read data) |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the core with its default parameters: 1024 words of two 9-bit bytes. Two byte lanes are enough to show a partial write and a partial merge that keep one lane and replace the other. The 10-bit address lets a burst start at an offset of 2 and wrap inside its group of four. Both modes are exercised by resetting with flow_thru at 0 and then at 1, so the one-edge and two-edge late-write timings and both read latencies are checked against the same array.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_t;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2
    } bst_t;
endpackage

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr #(
    parameter int ADDR_W  = 10,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

    logic [ADDR_W-1:0] last;

    always_comb begin
        if (load)
            cur_addr = ext_addr;
        else
            cur_addr = {last[ADDR_W-1:BURST_W], last[BURST_W-1:0] + ONE};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last <= '0;
        else if (step_en)
            last <= cur_addr;
    end

    // continue cycles step only the low burst bits, wrapping
    assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |=> ((last[BURST_W-1:0] == $past(last[BURST_W-1:0]) + ONE) &&
                                (last[ADDR_W-1:BURST_W] == $past(last[ADDR_W-1:BURST_W]))));
endmodule

// File: rtl/zbt_cmd_fsm.sv
module zbt_cmd_fsm
    import zbt_pkg::*;
#(
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              adv,
    input  logic              we_n,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    output op_t               op,
    output logic [NBYTES-1:0] be,
    output logic              load
);
    bst_t state, state_nx;
    logic selected;

    assign selected = !ce1_n && ce2 && !ce3_n;

    always_comb begin
        state_nx = state;
        if (!adv) begin
            if (!selected)
                state_nx = ST_DESEL;
            else if (we_n)
                state_nx = ST_RD;
            else
                state_nx = ST_WR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_DESEL;
        else if (step_en)
            state <= state_nx;
    end

    always_comb begin
        be   = ~bw_n;
        load = !adv;
        op   = OP_NOP;
        unique case (state_nx)
            ST_RD:    op = OP_RD;
            ST_WR:    op = (|be) ? OP_WR : OP_NOP;
            ST_DESEL: op = OP_NOP;
            default:  op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
    parameter  int DEPTH  = 1024,
    parameter  int NBYTES = 2,
    parameter  int BYTE_W = 9,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_be[b])
                    mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // an aborted write must never reach the array
    assert_wr_has_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be != '0));
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter  int DEPTH  = 1024,
    parameter  int NBYTES = 2,
    parameter  int BYTE_W = 9,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  logic              cke_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv,
    input  logic              we_n,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              step_en;
    op_t               cmd_op;
    logic [NBYTES-1:0] cmd_be;
    logic              cmd_load;
    logic [ADDR_W-1:0] cmd_addr;

    op_t               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [NBYTES-1:0] s1_be, s2_be;

    op_t               wr_op;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_be;

    logic [DATA_W-1:0] rd_raw, rd_merged, q_reg;
    logic              q_vld, hit, drive;

    assign step_en = !cke_n && !sleep;

    zbt_cmd_fsm #(.NBYTES(NBYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .op(cmd_op), .be(cmd_be), .load(cmd_load)
    );

    zbt_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(2)) u_ctr (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load(cmd_load),
        .ext_addr(addr), .cur_addr(cmd_addr)
    );

    // late-write queue: stage 1 = address cycle, stage 2 = one edge later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= OP_NOP;
            s1_addr <= '0;
            s1_be   <= '0;
            s2_op   <= OP_NOP;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (step_en) begin
            s1_op   <= cmd_op;
            s1_addr <= cmd_addr;
            s1_be   <= cmd_be;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    always_comb begin
        if (flow_thru) begin
            wr_op   = s1_op;
            wr_addr = s1_addr;
            wr_be   = s1_be;
        end else begin
            wr_op   = s2_op;
            wr_addr = s2_addr;
            wr_be   = s2_be;
        end
    end

    assign wr_en = step_en && (wr_op == OP_WR);

    zbt_store #(.DEPTH(DEPTH), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(dq_in), .rd_addr(s1_addr), .rd_data(rd_raw)
    );

    // pipelined read meets the write whose data lands on the same edge
    assign hit = !flow_thru && (s2_op == OP_WR) && (s2_addr == s1_addr);

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign rd_merged[b*BYTE_W +: BYTE_W] = (hit && s2_be[b]) ?
            dq_in[b*BYTE_W +: BYTE_W] : rd_raw[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q_reg <= '0;
        end else if (step_en) begin
            q_vld <= (s1_op == OP_RD);
            if (s1_op == OP_RD)
                q_reg <= rd_merged;
        end
    end

    assign drive  = flow_thru ? (s1_op == OP_RD) : q_vld;
    assign dq_oe  = drive && !oe_n && !sleep;
    assign dq_out = flow_thru ? rd_raw : q_reg;

    // a stalled edge leaves the queue and the output register untouched
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_n && !sleep) |=> ($stable(q_reg) && $stable(s1_op) && $stable(s2_op) && $stable(s2_addr)));

    // sleep freezes all synchronous state
    assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(q_vld) && $stable(s1_addr) && $stable(s2_op)));

    // a load that is not selected issues nothing
    assert_desel_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !adv && (ce1_n || !ce2 || ce3_n)) |=> (s1_op == OP_NOP));

    // never drive in a cycle whose data is taken as write data
    assert_no_turn_clash_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !dq_oe);
endmodule

// File: tb/sim_zbt_sram_core.sv
module sim_zbt_sram_core;
    logic        clk = 1'b0;
    logic        rst_n, flow_thru, cke_n, adv, we_n, ce1_n, ce2, ce3_n, oe_n, sleep;
    logic [9:0]  addr;
    logic [1:0]  bw_n;
    logic [17:0] dq_in, dq_out;
    logic        dq_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic        obs_oe;
    logic [17:0] obs_q;

    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] DES = 3'b110;
    localparam logic [17:0] D1 = 18'h1A5C3, D2 = 18'h0BEEF, D3 = 18'h0F0F0;
    localparam logic [17:0] D4 = 18'h3C3C3, D5 = 18'h12345, D6 = 18'h2B6D9;
    localparam logic [17:0] DA = 18'h01F3E, JUNK = 18'h3FFFF;

    always #10 clk = ~clk;

    zbt_sram_core u0 (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .cke_n(cke_n), .addr(addr),
        .adv(adv), .we_n(we_n), .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic check(input string req, input string what, input logic [17:0] got, input logic [17:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // one command per edge; captures the outputs of the previous cycle first
    task automatic step(input logic a_adv, input logic a_we, input logic [1:0] a_bw,
                        input logic [2:0] a_ce, input logic [9:0] a_addr, input logic [17:0] a_d);
        @(negedge clk);
        obs_oe = dq_oe;
        obs_q  = dq_out;
        adv    = a_adv;
        we_n   = a_we;
        bw_n   = a_bw;
        {ce1_n, ce2, ce3_n} = a_ce;
        addr   = a_addr;
        dq_in  = a_d;
    endtask

    task automatic nop(input logic [17:0] d);
        step(1'b0, 1'b1, 2'b11, DES, 10'd0, d);
    endtask
    task automatic wr(input logic [9:0] a, input logic [1:0] bw, input logic [17:0] d);
        step(1'b0, 1'b0, bw, SEL, a, d);
    endtask
    task automatic rd(input logic [9:0] a, input logic [17:0] d);
        step(1'b0, 1'b1, 2'b11, SEL, a, d);
    endtask
    task automatic cont(input logic [1:0] bw, input logic [17:0] d);
        step(1'b1, 1'b0, bw, SEL, 10'd0, d);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        flow_thru = mode;
        cke_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        adv = 1'b0; we_n = 1'b1; bw_n = 2'b11; {ce1_n, ce2, ce3_n} = DES;
        addr = '0; dq_in = '0;
        repeat (2) @(negedge clk);
        check("R1", "dq_oe in reset", dq_oe, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        nop(0);
        nop(0);
        check("R1", "dq_oe after reset", obs_oe, 1'b0);
    endtask

    task automatic t_pipe_basic();
        wr(10'd5, 2'b00, 0);
        nop(0);
        nop(D1);
        rd(10'd5, 0);
        nop(0);
        check("R2", "pipe not driven after address edge", obs_oe, 1'b0);
        nop(0);
        check("R2", "pipe driven one edge later", obs_oe, 1'b1);
        check("R4", "pipe double late write data", obs_q, D1);
    endtask

    task automatic t_rwr();
        rd(10'd5, 0);
        wr(10'd6, 2'b00, 0);
        rd(10'd5, 0);
        check("R13", "first read driven", obs_oe, 1'b1);
        check("R13", "first read data", obs_q, D1);
        nop(D3);
        check("R13", "bus released for write data", obs_oe, 1'b0);
        nop(0);
        check("R13", "second read driven", obs_oe, 1'b1);
        check("R13", "second read data", obs_q, D1);
        nop(0);
        rd(10'd6, 0);
        nop(0);
        nop(0);
        check("R4", "write between reads stored", obs_q, D3);
    endtask

    task automatic t_coherence();
        wr(10'd9, 2'b00, 0);
        rd(10'd9, 0);
        nop(D4);
        nop(0);
        check("R12", "read right after write merged", obs_q, D4);
        wr(10'd9, 2'b10, 0);
        rd(10'd9, 0);
        nop(D5);
        nop(0);
        nop(0);
        check("R12", "partial merge keeps upper byte", obs_q, {D4[17:9], D5[8:0]});
    endtask

    task automatic t_bytes();
        wr(10'd9, 2'b01, 0);
        nop(0);
        nop(D6);
        nop(0);
        rd(10'd9, 0);
        nop(0);
        nop(0);
        check("R8", "byte1 only written", obs_q, {D6[17:9], D5[8:0]});
    endtask

    task automatic t_abort();
        wr(10'd9, 2'b11, 0);
        nop(0);
        nop(JUNK);
        check("R7", "abort bus undriven", obs_oe, 1'b0);
        nop(0);
        check("R7", "abort data cycle undriven", obs_oe, 1'b0);
        rd(10'd9, 0);
        nop(0);
        nop(0);
        check("R7", "abort leaves word", obs_q, {D6[17:9], D5[8:0]});
    endtask

    task automatic t_stall();
        rd(10'd5, 0);
        nop(0);
        wr(10'd5, 2'b00, 0);
        cke_n = 1'b1;
        check("R9", "read driven before stall", obs_oe, 1'b1);
        nop(D6);
        cke_n = 1'b0;
        check("R9", "read still driven in stall", obs_oe, 1'b1);
        check("R9", "read data held in stall", obs_q, D1);
        nop(D6);
        nop(D6);
        rd(10'd5, 0);
        nop(0);
        nop(0);
        check("R9", "stalled write ignored", obs_q, D1);
    endtask

    task automatic t_oe();
        rd(10'd5, 0);
        nop(0);
        nop(0);
        oe_n = 1'b1;
        #1;
        check("R10", "oe_n forces off", dq_oe, 1'b0);
        oe_n = 1'b0;
        #1;
        check("R10", "drive returns", dq_oe, 1'b1);
        check("R10", "data unchanged", dq_out, D1);
    endtask

    task automatic t_sleep();
        rd(10'd5, 0);
        nop(0);
        nop(0);
        sleep = 1'b1;
        #1;
        check("R11", "sleep forces off", dq_oe, 1'b0);
        wr(10'd5, 2'b00, 0);
        nop(JUNK);
        check("R11", "undriven while asleep", obs_oe, 1'b0);
        nop(JUNK);
        sleep = 1'b0;
        nop(0);
        nop(0);
        rd(10'd5, 0);
        nop(0);
        nop(0);
        check("R11", "write during sleep ignored", obs_q, D1);
    endtask

    task automatic t_flow();
        wr(10'd7, 2'b00, 0);
        nop(D2);
        check("R4", "flow write cycle undriven", obs_oe, 1'b0);
        rd(10'd7, 0);
        nop(0);
        check("R3", "flow read driven", obs_oe, 1'b1);
        check("R3", "flow single late write data", obs_q, D2);
    endtask

    task automatic t_burst();
        wr(10'd14, 2'b00, 0);
        cont(2'b00, 18'h00011);
        cont(2'b00, 18'h00022);
        cont(2'b00, 18'h00033);
        nop(18'h00044);
        rd(10'd12, 0);
        cont(2'b11, 0);
        check("R6", "burst word at 12", obs_q, 18'h00033);
        cont(2'b11, 0);
        check("R6", "burst word at 13", obs_q, 18'h00044);
        cont(2'b11, 0);
        check("R6", "burst word at 14", obs_q, 18'h00011);
        nop(0);
        check("R6", "burst wrap word at 15", obs_q, 18'h00022);
    endtask

    task automatic t_desel();
        wr(10'd30, 2'b00, 0);
        nop(DA);
        step(1'b0, 1'b0, 2'b00, 3'b000, 10'd30, 0);
        cont(2'b00, JUNK);
        nop(JUNK);
        check("R5", "deselected write undriven", obs_oe, 1'b0);
        step(1'b0, 1'b1, 2'b11, 3'b011, 10'd30, 0);
        nop(0);
        check("R5", "deselected read undriven", obs_oe, 1'b0);
        rd(10'd30, 0);
        nop(0);
        check("R13", "deselect continue wrote nothing", obs_q, DA);
        check("R5", "selected read driven", obs_oe, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; flow_thru = 1'b0; cke_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        adv = 1'b0; we_n = 1'b1; bw_n = 2'b11; {ce1_n, ce2, ce3_n} = DES;
        addr = '0; dq_in = '0;
        do_reset(1'b0);
        t_reset();
        t_pipe_basic();
        t_rwr();
        t_coherence();
        t_bytes();
        t_abort();
        t_stall();
        t_oe();
        t_sleep();
        do_reset(1'b1);
        t_flow();
        t_burst();
        t_desel();
        finish_up();
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: got 0 expected 1");
            finish_up();
        end
    end
endmodule